// File: doc/BRIEF.md
# Branch Trace Buffer with Compression

The block keeps a short history of the program-flow discontinuities that a processor core reports. Each discontinuity arrives as a branch source address and a branch target address, and the pair is stored as one entry in a circular buffer of `DEPTH` entries. Software reads the history back through a small register port, one word at a time. Reads of the data register are destructive: the oldest entry comes out first, target word before source word, and the entry leaves the buffer once both words have been read.

Tight loops would otherwise fill the buffer with copies of the same branch. A new pair that equals the newest stored entry is dropped, and bit 0 of that entry's target address is set to show it. A new pair that equals the second-newest entry is dropped as well, and bit 0 of that entry's source address is set. Addresses are halfword aligned, so bit 0 is ignored in these comparisons.

Capture runs only when both the power bit and the enable bit of the control register are set. A third control bit stops capture while the core runs an exception, NMI or reset handler. When the buffer is full, a new entry overwrites the oldest one.

Top module: `btb_trace_buffer`

## Requirements
- R1: The first read of the data register (address 2) returns the oldest entry's target address. The second read returns that entry's source address. Entries are read out in the order they were captured.
- R2: The status register (address 1) holds the valid-entry count in its low bits. The count drops by one on every second data read.
- R3: Exactly twice the count in data reads empties the buffer. A data read while the count is zero returns 0 and leaves the count at zero.
- R4: A captured pair that equals the newest entry, with bit 0 ignored, is not stored. Bit 0 of the newest entry's target address is set instead.
- R5: A captured pair that equals the second-newest entry, with bit 0 ignored, is not stored. Bit 0 of that entry's source address is set instead. This applies only when the pair does not match the newest entry.
- R6: The control register is at address 0. Bit 0 is power and bit 1 is enable. Capture happens only when both bits read back as 1. A write that sets enable while power is 0 leaves enable at 0.
- R7: Control bit 2 set means that a discontinuity reported with the handler flag high is not recorded. Discontinuities reported with the handler flag low are still recorded.
- R8: The buffer holds `DEPTH` (16) entries. When it is full, a new entry replaces the oldest one and the count stays at 16.
- R9: When a capture and a data read happen in the same cycle, the read returns the value that was stored before that cycle. The count afterwards reflects both operations.
- R10: After reset, the control register reads 0 and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_valid | input | 1 | Discontinuity reported this cycle |
| trc_src | input | AW | Branch source address (halfword aligned) |
| trc_tgt | input | AW | Branch target address (halfword aligned) |
| trc_in_handler | input | 1 | Core is in an exception, NMI or reset handler |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reading the data register consumes a word) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 3 | Control write data {skip, enable, power} |
| reg_rdata | output | AW | Read data for the selected register, valid in the same cycle |

## Verification
The assertions assume that the inputs are free of X after reset and that `reg_rd` is held for a single cycle for each word read. They also assume that addresses arrive with bit 0 clear, because a set bit would look like a compression flag. The stimulus uses only aligned addresses and pulses every strobe for exactly one clock. Combined capture-and-read cycles are issued only when the buffer is neither empty nor full, so that a read never targets an entry that is being overwritten in the same cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_W   = 3;
    localparam int BIT_PWR  = 0;
    localparam int BIT_EN   = 1;
    localparam int BIT_SKIP = 2;
endpackage

// File: rtl/btb_ctrl.sv
module btb_ctrl
    import btb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic              pwr,
    output logic              en,
    output logic              skip
);
    typedef struct packed {
        logic pwr;
        logic en;
        logic skip;
    } ctrl_t;

    ctrl_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (wr) begin
            c_d.pwr  = wdata[BIT_PWR];
            // enable cannot be set, and is cleared, while power is off
            c_d.en   = wdata[BIT_EN] & wdata[BIT_PWR];
            c_d.skip = wdata[BIT_SKIP];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pwr  = c_q.pwr;
    assign en   = c_q.en;
    assign skip = c_q.skip;

    p_en_needs_pwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.en |-> c_q.pwr);

    p_en_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[BIT_PWR]) |=> !c_q.en);
endmodule

// File: rtl/btb_match.sv
module btb_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] new_src,
    input  logic [AW-1:0] new_tgt,
    input  logic          have1,
    input  logic [AW-1:0] e1_src,
    input  logic [AW-1:0] e1_tgt,
    input  logic          have2,
    input  logic [AW-1:0] e2_src,
    input  logic [AW-1:0] e2_tgt,
    output logic          hit1,
    output logic          hit2
);
    localparam logic [AW-1:0] MASK = {{(AW-1){1'b1}}, 1'b0};

    logic eq1, eq2;

    always_comb begin
        eq1  = ((new_src & MASK) == (e1_src & MASK)) && ((new_tgt & MASK) == (e1_tgt & MASK));
        eq2  = ((new_src & MASK) == (e2_src & MASK)) && ((new_tgt & MASK) == (e2_tgt & MASK));
        hit1 = have1 && eq1;
        hit2 = have2 && eq2 && !hit1;
    end
endmodule

// File: rtl/btb_trace_buffer.sv
module btb_trace_buffer
    import btb_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trc_valid,
    input  logic [AW-1:0]     trc_src,
    input  logic [AW-1:0]     trc_tgt,
    input  logic              trc_in_handler,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [AW-1:0]     reg_rdata
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] tgt;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [IW-1:0]      head;
        logic [CW-1:0]      count;
        logic               phase;
    } state_t;

    state_t s_q, s_d;

    logic pwr, en, skip;
    logic ctrl_wr;
    logic [IW-1:0] idx_n1, idx_n2, idx_old;
    logic hit1, hit2;
    logic cap_fire, rd_data, rd_live, pop;
    logic [CW-1:0] cnt;

    assign ctrl_wr = reg_wr && (reg_addr == REG_CTRL);

    btb_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .wdata (reg_wdata),
        .pwr   (pwr),
        .en    (en),
        .skip  (skip)
    );

    assign idx_n1  = s_q.head - IW'(1);
    assign idx_n2  = s_q.head - IW'(2);
    // count of DEPTH truncates to 0, so the oldest sits at head when full
    assign idx_old = s_q.head - IW'(s_q.count);

    btb_match #(.AW(AW)) u_match (
        .new_src (trc_src),
        .new_tgt (trc_tgt),
        .have1   (s_q.count >= CW'(1)),
        .e1_src  (s_q.mem[idx_n1].src),
        .e1_tgt  (s_q.mem[idx_n1].tgt),
        .have2   (s_q.count >= CW'(2)),
        .e2_src  (s_q.mem[idx_n2].src),
        .e2_tgt  (s_q.mem[idx_n2].tgt),
        .hit1    (hit1),
        .hit2    (hit2)
    );

    assign cap_fire = trc_valid && pwr && en && !(skip && trc_in_handler);
    assign rd_data  = reg_rd && (reg_addr == REG_DATA);
    assign rd_live  = rd_data && (s_q.count != '0);
    assign pop      = rd_live && s_q.phase;

    always_comb begin
        s_d = s_q;
        cnt = s_q.count;
        if (cap_fire) begin
            if (hit1) begin
                s_d.mem[idx_n1].tgt[0] = 1'b1;
            end else if (hit2) begin
                s_d.mem[idx_n2].src[0] = 1'b1;
            end else begin
                s_d.mem[s_q.head].src = trc_src;
                s_d.mem[s_q.head].tgt = trc_tgt;
                s_d.head = s_q.head + IW'(1);
                if (s_q.count != FULL) cnt = s_q.count + CW'(1);
            end
        end
        if (rd_live) begin
            s_d.phase = ~s_q.phase;
            if (pop) cnt = cnt - CW'(1);
        end
        s_d.count = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_CTRL: reg_rdata = AW'({skip, en, pwr});
            REG_STAT: reg_rdata = AW'(s_q.count);
            REG_DATA: reg_rdata = (s_q.count == '0) ? '0 :
                                  (s_q.phase ? s_q.mem[idx_old].src : s_q.mem[idx_old].tgt);
            default:  reg_rdata = '0;
        endcase
    end

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= FULL);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(s_q.count) <= int'($past(s_q.count)) + 1) &&
                 (int'(s_q.count) + 1 >= int'($past(s_q.count))));

    p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && s_q.count == '0 && !trc_valid) |=> s_q.count == '0);

    p_repeat_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && hit1 && !rd_data) |=> $stable(s_q.count));

    p_repeat_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && hit2 && !rd_data) |=> $stable(s_q.head));

    p_handler_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (skip && trc_in_handler && !rd_data) |=> $stable(s_q.count));

    p_hits_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit1, hit2}));
endmodule

// File: tb/test_btb_trace_buffer.sv
module test_btb_trace_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trc_valid = 1'b0;
    logic [31:0] trc_src = '0;
    logic [31:0] trc_tgt = '0;
    logic        trc_in_handler = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [2:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_src[$];
    logic [31:0] m_tgt[$];
    bit          m_phase = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        mon_ev;

    always #5 clk = ~clk;

    btb_trace_buffer i_btb_trace_buffer (
        .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_src(trc_src),
        .trc_tgt(trc_tgt), .trc_in_handler(trc_in_handler), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops the expected word queued by the driver and compares
    initial forever begin
        @(mon_ev);
        if (exp_q.size() != 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(reg_rdata === e, t, reg_rdata, e);
        end
    end

    function automatic void model_cap(input logic [31:0] s, input logic [31:0] t);
        int n;
        n = m_src.size();
        if (n >= 1 && (s & ~32'h1) == (m_src[n-1] & ~32'h1) && (t & ~32'h1) == (m_tgt[n-1] & ~32'h1))
            m_tgt[n-1][0] = 1'b1;
        else if (n >= 2 && (s & ~32'h1) == (m_src[n-2] & ~32'h1) && (t & ~32'h1) == (m_tgt[n-2] & ~32'h1))
            m_src[n-2][0] = 1'b1;
        else begin
            m_src.push_back(s);
            m_tgt.push_back(t);
            if (m_src.size() > 16) begin
                void'(m_src.pop_front());
                void'(m_tgt.pop_front());
            end
        end
    endfunction

    function automatic logic [31:0] model_read();
        logic [31:0] v;
        if (m_src.size() == 0) return 32'h0;
        v = m_phase ? m_src[0] : m_tgt[0];
        if (m_phase) begin
            void'(m_src.pop_front());
            void'(m_tgt.pop_front());
        end
        m_phase = ~m_phase;
        return v;
    endfunction

    task automatic write_ctrl(input logic [2:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic capture(input logic [31:0] s, input logic [31:0] t, input bit hnd, input bit live);
        @(negedge clk);
        trc_valid = 1'b1; trc_src = s; trc_tgt = t; trc_in_handler = hnd;
        if (live) model_cap(s, t);
        @(negedge clk);
        trc_valid = 1'b0; trc_in_handler = 1'b0;
    endtask

    task automatic read_data(input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 2'd2;
        exp_q.push_back(model_read());
        tag_q.push_back(req);
        #2;
        ->mon_ev;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cap_and_read(input logic [31:0] s, input logic [31:0] t);
        @(negedge clk);
        trc_valid = 1'b1; trc_src = s; trc_tgt = t;
        reg_rd = 1'b1; reg_addr = 2'd2;
        exp_q.push_back(model_read());
        tag_q.push_back("R9 read during capture");
        model_cap(s, t);
        #2;
        ->mon_ev;
        @(negedge clk);
        trc_valid = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic drain(input string req);
        int n;
        n = 2 * m_src.size() - (m_phase ? 1 : 0);
        for (int i = 0; i < n; i++) read_data(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        read_reg(2'd0, 32'h0, "R10 ctrl after reset");
        read_reg(2'd1, 32'h0, "R10 count after reset");

        // R6 enable without power is refused and nothing is captured
        write_ctrl(3'b010);
        read_reg(2'd0, 32'h0, "R6 enable without power");
        capture(32'h100, 32'h200, 0, 0);
        read_reg(2'd1, 32'h0, "R6 no capture while off");
        write_ctrl(3'b001);
        capture(32'h104, 32'h204, 0, 0);
        read_reg(2'd1, 32'h0, "R6 no capture with power only");

        write_ctrl(3'b011);
        read_reg(2'd0, 32'h3, "R6 power and enable");
        capture(32'h100, 32'h200, 0, 1);
        capture(32'h110, 32'h210, 0, 1);
        capture(32'h120, 32'h220, 0, 1);
        read_reg(2'd1, 32'h3, "R1 three entries stored");

        // R4 repeat of newest, R5 repeat of second newest
        capture(32'h120, 32'h220, 0, 1);
        read_reg(2'd1, 32'h3, "R4 newest repeat dropped");
        capture(32'h110, 32'h210, 0, 1);
        read_reg(2'd1, 32'h3, "R5 second-newest repeat dropped");
        capture(32'h120, 32'h220, 0, 1);
        read_reg(2'd1, 32'h3, "R4 flagged entry still matches");

        // R2 count decrements every second read
        read_data("R1 first word target");
        read_reg(2'd1, 32'h3, "R2 count after one read");
        read_data("R1 second word source");
        read_reg(2'd1, 32'h2, "R2 count after two reads");
        drain("R4 R5 flagged words");
        read_reg(2'd1, 32'h0, "R3 empty after 2x count reads");
        read_data("R3 empty read returns zero");
        read_reg(2'd1, 32'h0, "R3 empty read keeps count");

        // R7 handler skip
        write_ctrl(3'b111);
        capture(32'h300, 32'h400, 1, 0);
        read_reg(2'd1, 32'h0, "R7 handler capture skipped");
        capture(32'h300, 32'h400, 0, 1);
        read_reg(2'd1, 32'h1, "R7 normal capture kept");
        drain("R7 readout");
        write_ctrl(3'b011);
        capture(32'h500, 32'h600, 1, 1);
        read_reg(2'd1, 32'h1, "R7 handler capture kept when skip off");
        drain("R7 readout");

        // R8 overflow
        for (int i = 0; i < 20; i++)
            capture(32'h1000 + 32'(i) * 8, 32'h8000 + 32'(i) * 8, 0, 1);
        read_reg(2'd1, 32'd16, "R8 count saturates");
        drain("R8 oldest overwritten");
        read_reg(2'd1, 32'h0, "R8 drained");

        // R9 simultaneous capture and read
        capture(32'h2000, 32'h3000, 0, 1);
        capture(32'h2010, 32'h3010, 0, 1);
        cap_and_read(32'h2020, 32'h3020);
        read_reg(2'd1, 32'h3, "R9 count after capture with first read");
        cap_and_read(32'h2030, 32'h3030);
        read_reg(2'd1, 32'h3, "R9 count after capture with pop");
        drain("R9 readout");
        read_reg(2'd1, 32'h0, "R9 drained");

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule